// File: doc/BRIEF.md
# Concurrent-Evaluation ALU with Condition Register

This block is a small arithmetic/logic unit for a datapath with an accumulator. It keeps two operands in its own input registers, loaded through separate load enables. Every primitive function (addition, subtraction, bitwise logic, pass-through) is evaluated from those two registers at once. A wide multiplexer, steered by the operation select, hands the requested value to a result register when a start strobe arrives.

The compare operation works differently. It subtracts the second operand from the first and records the outcome in a three-bit condition register that marks exactly one of greater, equal or less. It does not touch the result register. A following branch stage reads those flags. Both operands are unsigned, and arithmetic wraps at the operand width.

Top module: `conc_alu`

## Requirements
- R1: After reset `result` is 0 and `cond_flags` is 3'b000.
- R2: An operand register takes its input on a clock edge where its load enable is 1 and holds otherwise. A start in the same cycle as a load uses the value held before that edge.
- R3: Op code 0 (add) writes (A + B) mod 2^WIDTH to `result`.
- R4: Op code 1 (subtract) writes (A - B) mod 2^WIDTH to `result`.
- R5: Op codes 2, 3, 4 and 5 write A AND B, A OR B, A XOR B and NOT A to `result`.
- R6: Op code 6 (pass) writes B to `result`.
- R7: `result` and `cond_flags` change only on the edge that samples `start`=1, so the new value is visible one cycle after start. With `start`=0 both hold.
- R8: Op code 7 (compare) loads `cond_flags`, whose bit 2 is GT, bit 1 is EQ and bit 0 is LT, from the unsigned A - B: 3'b100 if A>B, 3'b010 if A==B, 3'b001 if A<B.
- R9: A compare leaves `result` unchanged.
- R10: Any op other than compare leaves `cond_flags` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | WIDTH | Data for operand A register |
| a_ld | input | 1 | Load enable for operand A |
| b_in | input | WIDTH | Data for operand B register |
| b_ld | input | 1 | Load enable for operand B |
| op_sel | input | 3 | Operation code |
| start | input | 1 | Perform the selected operation this edge |
| result | output | WIDTH | Result register |
| cond_flags | output | 3 | Condition register {GT, EQ, LT} |

## Verification
The bench targets carries and borrows that cross the width: 200+100 wrapping to 44 and 5-9 wrapping to 252. A design that truncated wrongly or compared signed values would get these wrong, and it would also misreport 0 against 255 as greater. Start pulses that share a cycle with new operand loads show whether the block computes from the registered operands or from the raw inputs. Back-to-back compare and arithmetic ops show whether a compare overwrites the result or an arithmetic op clears the flags.

// File: rtl/conc_alu_pkg.sv
package conc_alu_pkg;

   localparam int unsigned OP_BITS  = 3;
   localparam int unsigned OP_COUNT = 1 << OP_BITS;

   typedef enum logic [OP_BITS-1:0] {
      OP_ADD   = 3'd0,
      OP_SUB   = 3'd1,
      OP_AND   = 3'd2,
      OP_OR    = 3'd3,
      OP_XOR   = 3'd4,
      OP_NOTA  = 3'd5,
      OP_PASSB = 3'd6,
      OP_CMP   = 3'd7
   } alu_op_e;

   typedef struct packed {
      logic gt;
      logic eq;
      logic lt;
   } cond_t;

endpackage

// File: rtl/conc_alu_opreg.sv
module conc_alu_opreg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
   end
endmodule

// File: rtl/conc_alu_bank.sv
module conc_alu_bank
   import conc_alu_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0]                a,
   input  logic [WIDTH-1:0]                b,
   output logic [OP_COUNT-1:0][WIDTH-1:0] res
);
   always_comb begin
      res           = '0;
      res[OP_ADD]   = a + b;
      res[OP_SUB]   = a - b;
      res[OP_AND]   = a & b;
      res[OP_OR]    = a | b;
      res[OP_XOR]   = a ^ b;
      res[OP_NOTA]  = ~a;
      res[OP_PASSB] = b;
      res[OP_CMP]   = a - b;
   end
endmodule

// File: rtl/conc_alu_cmp.sv
module conc_alu_cmp
   import conc_alu_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output cond_t            cond
);
   logic [WIDTH:0] diff;

   always_comb begin
      diff    = {1'b0, a} - {1'b0, b};
      cond.lt = diff[WIDTH];
      cond.eq = (diff[WIDTH-1:0] == '0) && !diff[WIDTH];
      cond.gt = !diff[WIDTH] && (diff[WIDTH-1:0] != '0);
   end
endmodule

// File: rtl/conc_alu.sv
module conc_alu
   import conc_alu_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_in,
   input  logic             a_ld,
   input  logic [WIDTH-1:0] b_in,
   input  logic             b_ld,
   input  logic [2:0]       op_sel,
   input  logic             start,
   output logic [WIDTH-1:0] result,
   output logic [2:0]       cond_flags
);
   localparam int unsigned N_OPND = 2;

   if (WIDTH < 2) begin : g_width_chk
      $error("conc_alu: WIDTH must be at least 2");
   end

   logic [N_OPND-1:0][WIDTH-1:0] opnd_d;
   logic [N_OPND-1:0][WIDTH-1:0] opnd_q;
   logic [N_OPND-1:0]            opnd_ld;

   assign opnd_d  = {b_in, a_in};
   assign opnd_ld = {b_ld, a_ld};

   for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
      conc_alu_opreg #(.WIDTH(WIDTH)) u_reg (
         .clk  (clk),
         .rst_n(rst_n),
         .ld   (opnd_ld[i]),
         .d    (opnd_d[i]),
         .q    (opnd_q[i])
      );
   end

   logic [OP_COUNT-1:0][WIDTH-1:0] all_res;
   cond_t                          cmp_out;
   alu_op_e                        op;
   logic [WIDTH-1:0]               picked;

   conc_alu_bank #(.WIDTH(WIDTH)) u_bank (
      .a  (opnd_q[0]),
      .b  (opnd_q[1]),
      .res(all_res)
   );

   conc_alu_cmp #(.WIDTH(WIDTH)) u_cmp (
      .a   (opnd_q[0]),
      .b   (opnd_q[1]),
      .cond(cmp_out)
   );

   assign op     = alu_op_e'(op_sel);
   assign picked = all_res[op];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result     <= '0;
         cond_flags <= '0;
      end else if (start) begin
         if (op == OP_CMP) cond_flags <= cmp_out;
         else              result     <= picked;
      end
   end
endmodule

// File: rtl/conc_alu_chk.sv
module conc_alu_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [2:0]       op_sel,
   input logic [WIDTH-1:0] a_q,
   input logic [WIDTH-1:0] b_q,
   input logic [WIDTH-1:0] result,
   input logic [2:0]       cond_flags
);
   // R8: never more than one flag set
   a_r8_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cond_flags) <= 1);

   // R8: after a compare exactly one flag is set and GT matches the operands
   a_r8_cmp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_sel == 3'd7) |=> ($countones(cond_flags) == 1));

   a_r8_cmp_gt: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_sel == 3'd7) |=> (cond_flags[2] == ($past(a_q) > $past(b_q))));

   // R9: compare keeps the result
   a_r9_cmp_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_sel == 3'd7) |=> $stable(result));

   // R10: non-compare ops keep the flags
   a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_sel != 3'd7) |=> $stable(cond_flags));

   // R7: idle cycles change nothing
   a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(result) && $stable(cond_flags)));

   // R3: add wraps modulo 2^WIDTH
   a_r3_add_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_sel == 3'd0) |=> (result == WIDTH'($past(a_q) + $past(b_q))));
endmodule

bind conc_alu conc_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .op_sel    (op_sel),
   .a_q       (opnd_q[0]),
   .b_q       (opnd_q[1]),
   .result    (result),
   .cond_flags(cond_flags)
);

// File: tb/test_conc_alu.sv
module test_conc_alu;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic         a_ld = 1'b0, b_ld = 1'b0, start = 1'b0;
   logic [2:0]   op_sel = '0;
   logic [W-1:0] result;
   logic [2:0]   cond_flags;

   int n_vec = 0, n_bad = 0;
   int ma = 0, mb = 0, mres = 0, mflags = 0;
   bit done = 0;

   always #5 clk = ~clk;

   conc_alu #(.WIDTH(W)) i_conc_alu (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_ld(a_ld), .b_in(b_in),
      .b_ld(b_ld), .op_sel(op_sel), .start(start), .result(result),
      .cond_flags(cond_flags)
   );

   function automatic string auto_tag(bit st, int op);
      if (!st)         return "R7";
      if (op == 7)     return "R8";
      if (op == 0)     return "R3";
      if (op == 1)     return "R4";
      if (op <= 5)     return "R5";
      return "R6";
   endfunction

   function automatic int ref_op(int op, int a, int b);
      case (op)
         0: return (a + b) % 256;
         1: return (a - b + 256) % 256;
         2: return a & b;
         3: return a | b;
         4: return a ^ b;
         5: return 255 - a;
         default: return b;
      endcase
   endfunction

   task automatic compare_now(string tag);
      n_vec++;
      if (int'(result) != mres || int'(cond_flags) != mflags) begin
         n_bad++;
         $display("FAIL %s: result=%0d flags=%b expected result=%0d flags=%b",
                  tag, result, cond_flags, mres, mflags[2:0]);
      end
   endtask

   // one clock: drive, model the edge, check at the next falling edge
   task automatic cyc(bit al, int av, bit bl, int bv, bit st, int op, string tag);
      a_ld = al; a_in = W'(av); b_ld = bl; b_in = W'(bv);
      start = st; op_sel = 3'(op);
      @(posedge clk);
      if (st) begin
         if (op == 7) mflags = (ma > mb) ? 4 : ((ma == mb) ? 2 : 1);
         else         mres   = ref_op(op, ma, mb);
      end
      if (al) ma = av;
      if (bl) mb = bv;
      @(negedge clk);
      compare_now(tag == "" ? auto_tag(st, op) : tag);
   endtask

   task automatic load_ab(int av, int bv);
      cyc(1, av, 1, bv, 0, 0, "R2");
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL R7 watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare_now("R1");

      // R3 wrap
      load_ab(200, 100);
      cyc(0, 0, 0, 0, 1, 0, "R3");
      // R4 borrow wrap
      load_ab(5, 9);
      cyc(0, 0, 0, 0, 1, 1, "R4");
      // R5 logic ops
      load_ab(8'hA5, 8'h3C);
      for (int op = 2; op <= 5; op++) cyc(0, 0, 0, 0, 1, op, "R5");
      // R6 pass
      cyc(0, 0, 0, 0, 1, 6, "R6");
      // R8 compare: less, equal, greater, extremes
      load_ab(0, 255);   cyc(0, 0, 0, 0, 1, 7, "R8");
      load_ab(255, 0);   cyc(0, 0, 0, 0, 1, 7, "R8");
      load_ab(77, 77);   cyc(0, 0, 0, 0, 1, 7, "R8");
      // R9: compare after an add leaves result
      load_ab(10, 3);
      cyc(0, 0, 0, 0, 1, 0, "R3");
      cyc(0, 0, 0, 0, 1, 7, "R9");
      // R10: flags hold across non-compare ops
      for (int op = 0; op < 7; op++) cyc(0, 0, 0, 0, 1, op, "R10");
      // R7: idle cycles with changing inputs hold outputs
      cyc(0, 1, 0, 2, 0, 0, "R7");
      cyc(0, 50, 0, 60, 0, 7, "R7");
      // R2: start and load in the same cycle use old operands
      cyc(1, 250, 1, 1, 1, 0, "R2");
      cyc(0, 0, 0, 0, 1, 0, "R2");
      cyc(1, 9, 0, 0, 1, 7, "R2");
      cyc(0, 0, 0, 0, 1, 7, "R2");

      for (int i = 0; i < 400; i++)
         cyc($urandom_range(0, 1), $urandom_range(0, 255), $urandom_range(0, 1),
             $urandom_range(0, 255), $urandom_range(0, 1), $urandom_range(0, 7), "");

      // reset again mid-run
      rst_n = 1'b0; ma = 0; mb = 0; mres = 0; mflags = 0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare_now("R1");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule